// File: doc/BRIEF.md
# RS(7,3) Deframing Decoder

This block takes a 64-bit framed word and treats it as two independent 32-bit lanes. Each lane carries one shortened-alphabet Reed-Solomon (7,3) codeword over GF(8). Every 3-bit code symbol sits in the low bits of a 4-bit nibble, and the lane's top nibble is filler. The block drops the filler, decodes each lane, and corrects up to two wrong symbols anywhere in the codeword. From each lane it returns the low eight bits of the 9-bit message. The two bytes are joined into a 16-bit result.

Decoding is split into four registered steps:
- compute the four syndromes;
- solve a 2x2 system by Cramer's rule for the error-locator coefficients, dropping to a one-error locator when the determinant is zero;
- try all seven positions as locator roots;
- solve a second 2x2 system for the error magnitudes and apply them as whole-symbol XORs.

A word the block cannot repair leaves with its message symbols unchanged and raises a flag.

Top module: `rsd_deframe_decoder`

## Requirements
- R1: Lane l is `in_data[32l+31:32l]`. Code symbol j (j = 0..6, the coefficient of x^j) is lane bits `[4j+2:4j]`. Symbols 4, 5 and 6 form message bits [2:0], [5:3] and [8:6]. Message bits [7:0] of lane l appear on `out_data[8l+7:8l]`.
- R2: Lane bits [31:28] and each nibble's top bit (lane bit 4j+3) have no effect on any output.
- R3: Message bit 8 never reaches `out_data`.
- R4: A lane holding a valid codeword yields its message, with no flag. A valid codeword is a multiple of (x+α)(x+α²)(x+α³)(x+α⁴), where α = x in GF(8) modulo x³+x+1, and a symbol's value b2b1b0 means b2·α²+b1·α+b0.
- R5: A single wrong symbol, at any of the seven positions and with any nonzero error value, is corrected.
- R6: Any two wrong symbols, at any pair of positions and with any nonzero error values, are corrected.
- R7: When the syndromes are not all zero, the locator determinant is zero and S1 is zero, the lane is flagged and its message symbols pass through unchanged.
- R8: When the number of roots found differs from the locator degree, the lane is flagged and its message symbols pass through unchanged.
- R9: A result appears exactly 4 clock cycles after its input is accepted. One result is produced per input, and inputs may arrive on every cycle.
- R10: While reset is held, `out_valid`, `out_uncorr` and `out_data` are all zero.
- R11: `out_uncorr` is high only together with `out_valid`, and it is the OR of the flags of all lanes.
- R12: `out_data` keeps its last value in cycles that carry no new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a framed word on `in_data` |
| in_data | input | LANES*32 (64) | Framed word, lane 0 in the low bits |
| out_valid | output | 1 | Marks a decoded result |
| out_data | output | LANES*DATA_W (16) | Decoded bytes, lane 0 in the low bits |
| out_uncorr | output | 1 | At least one lane could not be repaired |

## Verification
The assertions assume that `in_valid` is a clean 0/1 level, sampled on rising edges, and that it is never unknown once reset is released. The latency and idle properties rely on this. The root-count bound relies only on the field arithmetic, so it holds for any lane content, including words with three or more errors. The stimulus changes inputs only on falling edges and holds `in_valid` at a defined level from time zero. It uses fully encoded words with known error patterns, so every locator state the assertions observe comes from a real decode.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   localparam int SYM_W  = 3;
   localparam int NIB_W  = 4;
   localparam int N_SYM  = 7;
   localparam int K_SYM  = 3;
   localparam int N_SYN  = N_SYM - K_SYM;
   localparam int LANE_W = 32;
   localparam int MSG_W  = K_SYM * SYM_W;

   typedef logic [SYM_W-1:0] gf_t;
   typedef gf_t [N_SYN-1:0]  synd_t;
   typedef gf_t [N_SYM-1:0]  cw_t;

   // antilog table: alpha^e, field built on x^3 + x + 1
   function automatic gf_t gf_alpha(input logic [2:0] e);
      case (e)
         3'd0: return 3'd1;
         3'd1: return 3'd2;
         3'd2: return 3'd4;
         3'd3: return 3'd3;
         3'd4: return 3'd6;
         3'd5: return 3'd7;
         3'd6: return 3'd5;
         default: return 3'd1;
      endcase
   endfunction

   // log table; zero has no log and maps to 0 (callers guard it)
   function automatic logic [2:0] gf_log(input gf_t a);
      case (a)
         3'd1: return 3'd0;
         3'd2: return 3'd1;
         3'd4: return 3'd2;
         3'd3: return 3'd3;
         3'd6: return 3'd4;
         3'd7: return 3'd5;
         3'd5: return 3'd6;
         default: return 3'd0;
      endcase
   endfunction

   function automatic gf_t gf_mul(input gf_t a, input gf_t b);
      logic [3:0] s;
      if (a == '0 || b == '0) return '0;
      s = {1'b0, gf_log(a)} + {1'b0, gf_log(b)};
      if (s >= 4'd7) s = s - 4'd7;
      return gf_alpha(s[2:0]);
   endfunction

   function automatic gf_t gf_div(input gf_t a, input gf_t b);
      logic [3:0] s;
      if (a == '0 || b == '0) return '0;
      s = {1'b0, gf_log(a)} + 4'd7 - {1'b0, gf_log(b)};
      if (s >= 4'd7) s = s - 4'd7;
      return gf_alpha(s[2:0]);
   endfunction

endpackage

// File: rtl/rsd_synd_loc.sv
module rsd_synd_loc
   import rsd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_a,
   input  logic              en_b,
   input  logic [LANE_W-1:0] lane_i,
   output logic [MSG_W-1:0]  msg_o,
   output gf_t               s1_o,
   output gf_t               s2_o,
   output gf_t               sig1_o,
   output gf_t               sig2_o,
   output logic [1:0]        deg_o,
   output logic              clean_o,
   output logic              fail_o
);

   cw_t              sym;
   logic             pad_unused;
   synd_t            syn_c;
   synd_t            syn_q;
   logic [MSG_W-1:0] msg_q;

   // strip filler: keep the low SYM_W bits of each nibble
   always_comb begin
      pad_unused = 1'b0;
      for (int j = 0; j < N_SYM; j++) begin
         sym[j]     = lane_i[NIB_W*j +: SYM_W];
         pad_unused = pad_unused ^ lane_i[NIB_W*j + SYM_W];
      end
      for (int k = N_SYM*NIB_W; k < LANE_W; k++)
         pad_unused = pad_unused ^ lane_i[k];
   end

   // S_i = r(alpha^i), i = 1..N_SYN
   always_comb begin
      for (int i = 0; i < N_SYN; i++) begin
         syn_c[i] = '0;
         for (int j = 0; j < N_SYM; j++)
            syn_c[i] = syn_c[i] ^ gf_mul(sym[j], gf_alpha(3'(((i + 1) * j) % N_SYM)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_q <= '0;
         msg_q <= '0;
      end else if (en_a) begin
         syn_q <= syn_c;
         msg_q <= {sym[6], sym[5], sym[4]};
      end
   end

   // locator by Cramer's rule on [[S1 S2][S2 S3]] [sig2 sig1]' = [S3 S4]'
   gf_t        det_c, sig1_c, sig2_c;
   logic [1:0] deg_c;
   logic       clean_c, fail_c;

   always_comb begin
      det_c   = gf_mul(syn_q[0], syn_q[2]) ^ gf_mul(syn_q[1], syn_q[1]);
      clean_c = (syn_q == '0);
      sig1_c  = '0;
      sig2_c  = '0;
      deg_c   = 2'd0;
      fail_c  = 1'b0;
      if (!clean_c) begin
         if (det_c != '0) begin
            sig2_c = gf_div(gf_mul(syn_q[2], syn_q[2]) ^ gf_mul(syn_q[1], syn_q[3]), det_c);
            sig1_c = gf_div(gf_mul(syn_q[0], syn_q[3]) ^ gf_mul(syn_q[1], syn_q[2]), det_c);
            deg_c  = 2'd2;
         end else if (syn_q[0] != '0) begin
            sig1_c = gf_div(syn_q[1], syn_q[0]);
            deg_c  = 2'd1;
         end else begin
            fail_c = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_o   <= '0;
         s1_o    <= '0;
         s2_o    <= '0;
         sig1_o  <= '0;
         sig2_o  <= '0;
         deg_o   <= '0;
         clean_o <= 1'b0;
         fail_o  <= 1'b0;
      end else if (en_b) begin
         msg_o   <= msg_q;
         s1_o    <= syn_q[0];
         s2_o    <= syn_q[1];
         sig1_o  <= sig1_c;
         sig2_o  <= sig2_c;
         deg_o   <= deg_c;
         clean_o <= clean_c;
         fail_o  <= fail_c;
      end
   end

endmodule

// File: rtl/rsd_search_fix.sv
module rsd_search_fix
   import rsd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_a,
   input  logic             en_b,
   input  logic [MSG_W-1:0] msg_i,
   input  gf_t              s1_i,
   input  gf_t              s2_i,
   input  gf_t              sig1_i,
   input  gf_t              sig2_i,
   input  logic [1:0]       deg_i,
   input  logic             clean_i,
   input  logic             fail_i,
   output logic [MSG_W-1:0] msg_o,
   output logic             unc_o
);

   // root search: position j is in error when sigma(alpha^-j) == 0
   logic [N_SYM-1:0] mask_c;
   gf_t              ev;

   always_comb begin
      for (int j = 0; j < N_SYM; j++) begin
         ev = 3'd1
            ^ gf_mul(sig1_i, gf_alpha(3'((N_SYM - j) % N_SYM)))
            ^ gf_mul(sig2_i, gf_alpha(3'((2*N_SYM - 2*j) % N_SYM)));
         mask_c[j] = (ev == '0);
      end
   end

   logic [N_SYM-1:0] mask_q;
   logic [MSG_W-1:0] msg_q;
   gf_t              s1_q, s2_q;
   logic [1:0]       deg_q;
   logic             clean_q, fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         msg_q   <= '0;
         s1_q    <= '0;
         s2_q    <= '0;
         deg_q   <= '0;
         clean_q <= 1'b0;
         fail_q  <= 1'b0;
      end else if (en_a) begin
         mask_q  <= mask_c;
         msg_q   <= msg_i;
         s1_q    <= s1_i;
         s2_q    <= s2_i;
         deg_q   <= deg_i;
         clean_q <= clean_i;
         fail_q  <= fail_i;
      end
   end

   // R8
   root_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask_q) <= int'(deg_q));

   // error values by Cramer's rule on [[X1 X2][X1^2 X2^2]] [Y1 Y2]' = [S1 S2]'
   logic [2:0]       p_lo, p_hi, cnt;
   gf_t              x1, x2, e_det, y1, y2;
   logic [MSG_W-1:0] fix_c;
   logic             unc_c;

   always_comb begin
      p_lo = '0;
      p_hi = '0;
      for (int j = N_SYM - 1; j >= 0; j--)
         if (mask_q[j]) p_lo = 3'(j);
      for (int j = 0; j < N_SYM; j++)
         if (mask_q[j]) p_hi = 3'(j);
      cnt   = 3'($countones(mask_q));
      x1    = gf_alpha(p_lo);
      x2    = gf_alpha(p_hi);
      e_det = gf_mul(gf_mul(x1, x2), x1 ^ x2);
      y1    = '0;
      y2    = '0;
      unc_c = 1'b0;
      if (clean_q) begin
         unc_c = 1'b0;
      end else if (fail_q || cnt != {1'b0, deg_q}) begin
         unc_c = 1'b1;
      end else if (deg_q == 2'd1) begin
         y1 = gf_div(s1_q, x1);
      end else begin
         y1 = gf_div(gf_mul(s1_q, gf_mul(x2, x2)) ^ gf_mul(s2_q, x2), e_det);
         y2 = gf_div(gf_mul(s2_q, x1) ^ gf_mul(s1_q, gf_mul(x1, x1)), e_det);
      end
      fix_c = msg_q;
      for (int k = 0; k < K_SYM; k++) begin
         if (p_lo == 3'(N_SYN + k)) fix_c[SYM_W*k +: SYM_W] = fix_c[SYM_W*k +: SYM_W] ^ y1;
         if (p_hi == 3'(N_SYN + k)) fix_c[SYM_W*k +: SYM_W] = fix_c[SYM_W*k +: SYM_W] ^ y2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_o <= '0;
         unc_o <= 1'b0;
      end else if (en_b) begin
         msg_o <= fix_c;
         unc_o <= unc_c;
      end
   end

endmodule

// File: rtl/rsd_deframe_decoder.sv
module rsd_deframe_decoder
   import rsd_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [LANES*LANE_W-1:0] in_data,
   output logic                    out_valid,
   output logic [LANES*DATA_W-1:0] out_data,
   output logic                    out_uncorr
);

   localparam int STAGES = 4;

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("rsd_deframe_decoder: LANES must lie in 1..8");
   end
   if (DATA_W < 1 || DATA_W > MSG_W) begin : g_bad_data
      $error("rsd_deframe_decoder: DATA_W must lie in 1..MSG_W");
   end

   logic [STAGES-1:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[STAGES-2:0], in_valid};
   end

   logic [LANES-1:0] unc_vec;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [MSG_W-1:0] msg_b, msg_fix;
      gf_t              s1, s2, sig1, sig2;
      logic [1:0]       deg;
      logic             clean, fail;

      rsd_synd_loc u_front (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_a    (in_valid),
         .en_b    (vpipe[0]),
         .lane_i  (in_data[LANE_W*l +: LANE_W]),
         .msg_o   (msg_b),
         .s1_o    (s1),
         .s2_o    (s2),
         .sig1_o  (sig1),
         .sig2_o  (sig2),
         .deg_o   (deg),
         .clean_o (clean),
         .fail_o  (fail)
      );

      rsd_search_fix u_back (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_a    (vpipe[1]),
         .en_b    (vpipe[2]),
         .msg_i   (msg_b),
         .s1_i    (s1),
         .s2_i    (s2),
         .sig1_i  (sig1),
         .sig2_i  (sig2),
         .deg_i   (deg),
         .clean_i (clean),
         .fail_i  (fail),
         .msg_o   (msg_fix),
         .unc_o   (unc_vec[l])
      );

      assign out_data[DATA_W*l +: DATA_W] = msg_fix[DATA_W-1:0];

      if (DATA_W < MSG_W) begin : g_drop
         logic drop_unused;
         assign drop_unused = ^msg_fix[MSG_W-1:DATA_W];
      end
   end

   assign out_valid  = vpipe[STAGES-1];
   assign out_uncorr = out_valid & (|unc_vec);

   // R9
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##4 out_valid);

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##4 !out_valid);

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vpipe[STAGES-2] |=> $stable(out_data));

endmodule

// File: tb/rsd_deframe_decoder_tb.sv
module rsd_deframe_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;
   logic        out_uncorr;

   always #2.5 clk = ~clk;

   rsd_deframe_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_uncorr (out_uncorr)
   );

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 0;

   logic [2:0]  gcoef [0:4];
   logic [16:0] exp_v [0:2047];
   string       exp_tag [0:2047];
   int          wr_idx = 0;
   int          rd_idx = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
      total++;
      if (got !== expv) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, expv);
      end
   endtask

   // field multiply by shift and reduce with x^3 + x + 1
   function automatic logic [2:0] bmul(input logic [2:0] a, input logic [2:0] b);
      logic [5:0] p = '0;
      for (int i = 0; i < 3; i++) if (b[i]) p = p ^ ({3'b0, a} << i);
      for (int k = 5; k >= 3; k--) if (p[k]) p = p ^ (6'b001011 << (k - 3));
      return p[2:0];
   endfunction

   function automatic logic [2:0] bpow(input int k);
      logic [2:0] r = 3'd1;
      for (int i = 0; i < k; i++) r = bmul(r, 3'd2);
      return r;
   endfunction

   function automatic logic [20:0] rs_encode(input logic [8:0] msg);
      logic [2:0] r0 = '0, r1 = '0, r2 = '0, r3 = '0, fb;
      for (int k = 2; k >= 0; k--) begin
         fb = msg[3*k +: 3] ^ r3;
         r3 = r2 ^ bmul(fb, gcoef[3]);
         r2 = r1 ^ bmul(fb, gcoef[2]);
         r1 = r0 ^ bmul(fb, gcoef[1]);
         r0 = bmul(fb, gcoef[0]);
      end
      return {msg, r3, r2, r1, r0};
   endfunction

   function automatic logic [31:0] mk_lane(input logic [8:0] msg, input logic [20:0] err,
                                           input logic [10:0] pad);
      logic [20:0] r = rs_encode(msg) ^ err;
      logic [31:0] w;
      w[31:28] = pad[3:0];
      for (int j = 0; j < 7; j++) w[4*j +: 4] = {pad[4+j], r[3*j +: 3]};
      return w;
   endfunction

   function automatic logic [20:0] sym_err(input int p, input int v);
      return 21'(v) << (3*p);
   endfunction

   task automatic send(input string tag, input logic [31:0] l1, input logic [31:0] l0,
                       input logic [15:0] ed, input logic eu);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {l1, l0};
      exp_v[wr_idx]   = {eu, ed};
      exp_tag[wr_idx] = tag;
      wr_idx++;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 64'hA5A5_5A5A_F0F0_0F0F;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rd_idx < wr_idx) begin
            chk(exp_tag[rd_idx], {15'b0, out_uncorr, out_data}, {15'b0, exp_v[rd_idx]});
         end else begin
            chk("R9 extra result", 32'(rd_idx), 32'(wr_idx));
         end
         rd_idx++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog got=%0d exp=%0d", cycles, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [8:0]  m0, m1;
      logic [15:0] last;
      int n;

      gcoef[0] = 3'd1;
      for (int j = 1; j < 5; j++) gcoef[j] = 3'd0;
      for (int i = 1; i <= 4; i++) begin
         for (int j = 4; j >= 1; j--) gcoef[j] = gcoef[j-1] ^ bmul(bpow(i), gcoef[j]);
         gcoef[0] = bmul(bpow(i), gcoef[0]);
      end

      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 reset state", {14'b0, out_valid, out_uncorr, out_data}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R9 latency: result appears after the 4th edge, not the 3rd
      send("R9 latency result", mk_lane(9'h0AB, '0, '0), mk_lane(9'h0CD, '0, '0), 16'hABCD, 1'b0);
      idle(3);
      chk("R9 not before 4 cycles", {31'b0, out_valid}, 32'h0);
      @(negedge clk);
      chk("R9 valid at 4 cycles", {31'b0, out_valid}, 32'h1);
      idle(4);

      // R1 R2 R3 R4 clean sweep with varied filler and message bit 8
      for (int i = 0; i < 256; i++) begin
         m0 = {i[0], 8'(i)};
         m1 = {~i[1], 8'(255 - i)};
         send("R4 clean word (R1 R2 R3)",
              mk_lane(m1, '0, 11'(i * 37)), mk_lane(m0, '0, 11'(~(i * 13))),
              {m1[7:0], m0[7:0]}, 1'b0);
      end

      // R5 every position and nonzero value
      n = 0;
      for (int p = 0; p < 7; p++) begin
         for (int v = 1; v < 8; v++) begin
            m0 = 9'(n * 11 + 3);
            m1 = 9'(n * 7 + 100);
            send("R5 single error", mk_lane(m1, '0, 11'(n)), mk_lane(m0, sym_err(p, v), 11'(n * 5)),
                 {m1[7:0], m0[7:0]}, 1'b0);
            n++;
         end
      end

      // R6 every pair of positions and value pair; lane 1 also carries one error (R5)
      n = 0;
      for (int p1 = 0; p1 < 6; p1++)
         for (int p2 = p1 + 1; p2 < 7; p2++)
            for (int v1 = 1; v1 < 8; v1++)
               for (int v2 = 1; v2 < 8; v2++) begin
                  m0 = 9'(n * 29 + 5);
                  m1 = 9'(n * 3 + 77);
                  send("R6 double error",
                       mk_lane(m1, sym_err(n % 7, (n % 7) + 1), 11'(n * 3)),
                       mk_lane(m0, sym_err(p1, v1) ^ sym_err(p2, v2), 11'(n)),
                       {m1[7:0], m0[7:0]}, 1'b0);
                  n++;
               end

      // R7: error x^2 + a^4 x + a^3 gives S1 = S2 = 0, S3 != 0
      send("R7 S1 zero fallback", mk_lane(9'h1F0, '0, '0),
           mk_lane(9'h05A, sym_err(0, 3) ^ sym_err(1, 6) ^ sym_err(2, 1), '0), 16'hF05A, 1'b1);
      // R8: error x^2 + a^5 x + a^5 gives S2 = S3 = 0, S1 != 0, no root
      send("R8 root count mismatch", mk_lane(9'h033, '0, '0),
           mk_lane(9'h1C4, sym_err(0, 7) ^ sym_err(1, 7) ^ sym_err(2, 1), '0), 16'h33C4, 1'b1);
      // R11 flag from lane 1 alone
      send("R11 flag from upper lane",
           mk_lane(9'h099, sym_err(0, 7) ^ sym_err(1, 7) ^ sym_err(2, 1), '0),
           mk_lane(9'h011, '0, '0), 16'h9911, 1'b1);
      send("R11 clean after flag", mk_lane(9'h012, '0, '0), mk_lane(9'h034, '0, '0), 16'h1234, 1'b0);
      last = 16'h1234;

      idle(6);
      chk("R11 no flag when idle", {31'b0, out_uncorr}, 32'h0);
      chk("R12 output held", {16'b0, out_data}, {16'b0, last});
      chk("R9 one result per input", 32'(rd_idx), 32'(wr_idx));

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule